// File: doc/BRIEF.md
# Memory-Window Integer Multiply/Divide Unit

This block puts a 16-bit integer multiplier and divider on an 8-bit processor bus. It behaves like plain RAM. The processor stores two operands as bytes at fixed offsets in a small window. On any later bus cycle, including the one right after the last store, it loads the product, quotient or remainder from other offsets in the same window. There are no wait states, no busy flag and nothing to poll.

The operand bytes are registered. All arithmetic is combinational from those registers, and the read-back multiplexer is also combinational. A load therefore always shows the operands as they stood after the most recent clock edge. Each operand byte and each result byte has its own address. The operands can be read back. Stores to result offsets or unused offsets have no effect.

Top module: `mw_math_window`

## Requirements
- R1: A store (cs=1, rnw=0) to offset 0 or 1 sets the low or high byte of operand A. A load from that offset in any later cycle returns the stored byte.
- R2: A store to offset 2 or 3 sets the low or high byte of operand B. A load from that offset returns it.
- R3: Offsets 4 to 7 return the 32-bit unsigned product A×B, least significant byte at offset 4. The value is valid on the cycle right after the store that changed an operand.
- R4: When B is nonzero, offsets 8 and 9 return the unsigned quotient A/B and offsets 10 and 11 return A mod B, each little-endian.
- R5: When B is zero, the quotient reads 0xFFFF and the remainder reads A.
- R6: Stores to offsets 4 to 15 change nothing. Loads from offsets 12 to 15 return 0x00.
- R7: With cs=0, stores have no effect and rdata is 0x00.
- R8: After reset both operands are zero. The product therefore reads 0, the quotient reads 0xFFFF and the remainder reads 0.
- R9: Loads (rnw=1) never change any operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Window select |
| addr | input | 4 | Byte offset inside the window |
| rnw | input | 1 | 1 = load, 0 = store |
| wdata | input | 8 | Store data |
| rdata | output | 8 | Load data, combinational |

## Verification
The bench drives directed operand pairs and then a long run of random stores and loads. Every load is compared with a behavioural model. The directed pairs are zero, small values, A smaller than B, B equal to one, both operands at all ones, and B equal to zero. Between them they separate errors in the carry chain, errors in the quotient bit order, and wrong handling of the zero divisor. Loads placed on the cycle right after a store show whether results depend on stale operands. Stores aimed at result offsets, unused offsets and deselected cycles, each followed by read-back of both operands, show whether any write decode leaks.

// File: rtl/mw_pkg.sv
package mw_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      RG_OPA,
      RG_OPB,
      RG_PROD,
      RG_QUO,
      RG_REM,
      RG_NONE
   } region_e;
endpackage

// File: rtl/mw_operand_regs.sv
module mw_operand_regs #(
   parameter int OPW    = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rnw,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [OPW-1:0]    opa_q,
   output logic [OPW-1:0]    opb_q
);
   localparam int NB = OPW / mw_pkg::BYTE_W;

   logic wr;
   assign wr = cs && !rnw;

   for (genvar k = 0; k < NB; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            opa_q[k*8 +: 8] <= '0;
            opb_q[k*8 +: 8] <= '0;
         end else if (wr) begin
            if (addr == ADDR_W'(k))
               opa_q[k*8 +: 8] <= wdata;
            if (addr == ADDR_W'(NB + k))
               opb_q[k*8 +: 8] <= wdata;
         end
      end
   end

   // R1
   a_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !rnw && addr == '0) |=> (opa_q[7:0] == $past(wdata)));
   // R7
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && !rnw) |=> ($stable(opa_q) && $stable(opb_q)));
endmodule

// File: rtl/mw_arith.sv
module mw_arith #(
   parameter int OPW       = 16,
   parameter int MUL_SHIFT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPW-1:0]   opa,
   input  logic [OPW-1:0]   opb,
   output logic [2*OPW-1:0] prod,
   output logic [OPW-1:0]   quo,
   output logic [OPW-1:0]   rem
);
   localparam int PW = 2 * OPW;

   if (MUL_SHIFT != 0) begin : g_mul_shift
      always_comb begin
         prod = '0;
         for (int i = 0; i < OPW; i++)
            if (opb[i]) prod = prod + (PW'(opa) << i);
      end
   end else begin : g_mul_op
      assign prod = PW'(opa) * PW'(opb);
   end

   logic [OPW:0]   part;
   logic [OPW-1:0] q_raw;
   always_comb begin
      part  = '0;
      q_raw = '0;
      for (int i = OPW - 1; i >= 0; i--) begin
         part = {part[OPW-1:0], opa[i]};
         if (part >= {1'b0, opb}) begin
            part     = part - {1'b0, opb};
            q_raw[i] = 1'b1;
         end
      end
   end

   always_comb begin
      if (opb == '0) begin
         quo = '1;
         rem = opa;
      end else begin
         quo = q_raw;
         rem = part[OPW-1:0];
      end
   end

   // R5
   div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opb == '0) |-> (quo == '1 && rem == opa));
   // R4
   div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opb != '0) |-> ((PW'(quo) * PW'(opb) + PW'(rem)) == PW'(opa) && rem < opb));
endmodule

// File: rtl/mw_readmux.sv
module mw_readmux #(
   parameter int OPW    = 16,
   parameter int ADDR_W = 4
) (
   input  logic              cs,
   input  logic [ADDR_W-1:0] addr,
   input  logic [OPW-1:0]    opa,
   input  logic [OPW-1:0]    opb,
   input  logic [2*OPW-1:0]  prod,
   input  logic [OPW-1:0]    quo,
   input  logic [OPW-1:0]    rem,
   output logic [7:0]        rdata
);
   import mw_pkg::*;
   localparam int NB   = OPW / BYTE_W;
   localparam int USED = 6 * NB;

   logic [USED*8-1:0] flat;
   assign flat = {rem, quo, prod, opb, opa};

   region_e rg;
   always_comb begin
      rg = RG_NONE;
      if (int'(addr) < NB)          rg = RG_OPA;
      else if (int'(addr) < 2*NB)   rg = RG_OPB;
      else if (int'(addr) < 4*NB)   rg = RG_PROD;
      else if (int'(addr) < 5*NB)   rg = RG_QUO;
      else if (int'(addr) < USED)   rg = RG_REM;
   end

   always_comb begin
      rdata = '0;
      if (cs && rg != RG_NONE)
         for (int i = 0; i < USED; i++)
            if (addr == ADDR_W'(i)) rdata = flat[i*8 +: 8];
   end
endmodule

// File: rtl/mw_math_window.sv
module mw_math_window #(
   parameter int OPW       = 16,
   parameter int ADDR_W    = 4,
   parameter int MUL_SHIFT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rnw,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int NB = OPW / mw_pkg::BYTE_W;

   if (OPW % mw_pkg::BYTE_W != 0 || OPW < 8) begin : g_bad_w
      $error("OPW must be a positive multiple of 8");
   end
   if ((1 << ADDR_W) < 6 * NB) begin : g_bad_a
      $error("window too small for operand width");
   end

   logic [OPW-1:0]   opa, opb, quo, rem;
   logic [2*OPW-1:0] prod;

   mw_operand_regs #(.OPW(OPW), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rnw(rnw), .addr(addr),
      .wdata(wdata), .opa_q(opa), .opb_q(opb));

   mw_arith #(.OPW(OPW), .MUL_SHIFT(MUL_SHIFT)) u_arith (
      .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
      .prod(prod), .quo(quo), .rem(rem));

   mw_readmux #(.OPW(OPW), .ADDR_W(ADDR_W)) u_mux (
      .cs(cs), .addr(addr), .opa(opa), .opb(opb), .prod(prod),
      .quo(quo), .rem(rem), .rdata(rdata));

   // R3
   prod_low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rnw && addr == ADDR_W'(2*NB)) |-> (rdata == prod[7:0]));
   // R9
   load_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rnw) |=> ($stable(opa) && $stable(opb)));
   // R7
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> (rdata == 8'h00));
endmodule

// File: tb/mw_math_window_tb.sv
module mw_math_window_tb;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       cs = 0;
   logic [3:0] addr = 0;
   logic       rnw = 1;
   logic [7:0] wdata = 0;
   logic [7:0] rdata;

   int checks = 0;
   int failures = 0;
   int unsigned ma = 0, mb = 0;

   always #4 clk = ~clk;

   mw_math_window u_dut (.clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr),
      .rnw(rnw), .wdata(wdata), .rdata(rdata));

   function automatic logic [7:0] model(input int a);
      longint unsigned p;
      int unsigned q, r;
      p = longint'(ma) * longint'(mb);
      q = (mb == 0) ? 32'hFFFF : ma / mb;
      r = (mb == 0) ? ma : ma % mb;
      case (a)
         0: return ma[7:0];
         1: return ma[15:8];
         2: return mb[7:0];
         3: return mb[15:8];
         4, 5, 6, 7: return 8'(p >> (8*(a-4)));
         8: return q[7:0];
         9: return q[15:8];
         10: return r[7:0];
         11: return r[15:8];
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag(input int a);
      if (a < 2) return "R1";
      if (a < 4) return "R2";
      if (a < 8) return "R3";
      if (a < 12) return (mb == 0) ? "R5" : "R4";
      return "R6";
   endfunction

   task automatic wr(input int a, input int d, input bit sel);
      @(negedge clk);
      cs = sel; rnw = 0; addr = 4'(a); wdata = 8'(d);
      @(posedge clk);
      if (sel && a < 2) ma = (a == 0) ? {ma[31:8], 8'(d)} : {ma[31:16], 8'(d), ma[7:0]};
      if (sel && (a == 2 || a == 3)) mb = (a == 2) ? {mb[31:8], 8'(d)} : {mb[31:16], 8'(d), mb[7:0]};
   endtask

   task automatic rd(input int a, input string why);
      logic [7:0] e;
      @(negedge clk);
      cs = 1; rnw = 1; addr = 4'(a);
      #2;
      e = model(a);
      checks++;
      if (rdata !== e) begin
         failures++;
         $display("FAIL %s %s offset %0d: got %02h expected %02h", tag(a), why, a, rdata, e);
      end
   endtask

   task automatic set_ops(input int a, input int b);
      wr(0, a & 255, 1); wr(1, (a >> 8) & 255, 1);
      wr(2, b & 255, 1); wr(3, (b >> 8) & 255, 1);
   endtask

   task automatic read_all(input string why);
      for (int i = 0; i < 16; i++) rd(i, why);
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      read_all("R8 reset state");
      set_ops(7, 3);        read_all("small");
      set_ops(5, 9);        read_all("A below B");
      set_ops(16'hFFFF, 16'hFFFF); read_all("all ones");
      set_ops(16'h1234, 1); read_all("B one");
      set_ops(16'hBEEF, 0); read_all("R5 zero divisor");
      // result immediately after last operand store
      set_ops(300, 17); rd(4, "R3 next cycle"); rd(8, "R4 next cycle");
      // R6 stores to result/unused offsets ignored
      for (int i = 4; i < 16; i++) wr(i, 8'hA5, 1);
      read_all("R6 ignored stores");
      // R7 deselected stores ignored; rdata zero when idle
      for (int i = 0; i < 4; i++) wr(i, 8'h5A, 0);
      read_all("R7 deselected store");
      @(negedge clk); cs = 0; rnw = 1; addr = 4; #2;
      checks++;
      if (rdata !== 8'h00) begin
         failures++;
         $display("FAIL R7 idle rdata got %02h expected 00", rdata);
      end
      // R9 repeated loads leave operands intact
      for (int i = 0; i < 4; i++) rd(i, "R9 reload");
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 2) == 0) wr($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 3) != 0);
         else rd($urandom_range(0, 15), "random");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule